// File: doc/BRIEF.md
# Three-Channel Readout Merger with End-of-Readout Detection

The block collects bytes from three 8-bit readout channels into three per-channel FIFOs. A host enable mask selects the active channels. When a run starts, each active channel's FIFO first takes a host-supplied identifier byte. After that, the block drives a readout clock at half the master clock rate. On every rising edge of that clock it captures one byte from each active channel.

The FIFOs of channels 0 and 1 feed a shared 16-bit output stream. Channel 2 feeds an 8-bit stream of its own. Each active channel is watched for an end-of-readout marker. Once every active channel has shown it, the readout clock is allowed a fixed number of further rising edges and then parks low, and a completion flag rises.

Both output streams use valid/ready. A transfer happens in a cycle where valid and ready are both high. While valid is high and ready is low, the data on the stream holds steady and valid stays high. The sink may hold ready low for any length of time. The FIFOs keep absorbing input, with 2048 entries per channel.

Top module: `rdm_top`

## Requirements
- R1: After reset, `rd_clk_o`, `done_o`, `chan_done_o`, `pair_valid_o` and `solo_valid_o` are all 0.
- R2: A run begins only when `start_i` is high while the block is idle or finished, and `start_i` is ignored at every other time. At the start of a run, the mask on `chan_en_i` is captured. Each enabled channel k then writes its identifier byte `chan_id_i[8k+7:8k]` as the first byte of that run.
- R3: During readout, `rd_clk_o` toggles every master cycle. Each enabled channel that has not yet finished stores one byte, `chan_data_i[8k+7:8k]`, at each master edge where `rd_clk_o` rises.
- R4: A channel whose mask bit is 0 stores nothing and is not checked for the end marker.
- R5: A channel finishes when two bytes stored in a row both equal 0xFF. A lone 0xFF does not finish it. Both marker bytes are stored, nothing after them is stored, and `chan_done_o[k]` then rises.
- R6: Once all enabled channels are finished, `rd_clk_o` rises exactly four more times and then stays low. `done_o` rises together with the fourth of those edges and holds until the next run starts. With an empty mask, only those four edges occur.
- R7: Before the run finishes, `pair_valid_o` is high only when FIFOs 0 and 1 each hold at least three bytes. `pair_data_o` carries the channel 0 byte in bits 15:8 and the channel 1 byte in bits 7:0, and each transfer removes one byte from each FIFO.
- R8: While `done_o` is high, `pair_valid_o` is high whenever FIFOs 0 and 1 are both non-empty, so that leftover bytes drain.
- R9: While `pair_valid_o` is high and `pair_ready_i` is low, the next cycle keeps `pair_valid_o` high with `pair_data_o` unchanged.
- R10: `solo_valid_o` is high whenever FIFO 2 is non-empty. `solo_data_o` is its oldest byte, and each transfer removes one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run (idle or finished only) |
| chan_en_i | input | 3 | Channel enable mask, captured at start |
| chan_id_i | input | 24 | Identifier byte per channel, channel k in bits 8k+7:8k |
| chan_data_i | input | 24 | Readout byte per channel, channel k in bits 8k+7:8k |
| rd_clk_o | output | 1 | Readout clock, half master rate while active |
| chan_done_o | output | 3 | Per-channel end marker seen |
| done_o | output | 1 | Run complete, readout clock parked |
| pair_valid_o | output | 1 | Paired stream valid |
| pair_ready_i | input | 1 | Paired stream ready |
| pair_data_o | output | 16 | Channel 0 byte in 15:8, channel 1 byte in 7:0 |
| solo_valid_o | output | 1 | Channel 2 stream valid |
| solo_ready_i | input | 1 | Channel 2 stream ready |
| solo_data_o | output | 8 | Channel 2 byte |

## Verification
A wrong FIFO pointer or count shows up on a stream port as a wrong or extra byte, at the first transfer that reaches the bad entry. A marker detector stuck set or stuck clear shows within one readout edge. The channel either stops storing too early, or it keeps storing and the run never completes. A wrong tail counter changes how many times `rd_clk_o` rises before `done_o`, which is visible within a few cycles of the last marker. A threshold fault shows as `pair_valid_o` rising after the first stored data byte instead of the second.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IDW,
    ST_RUN,
    ST_TAIL,
    ST_FIN
  } rdm_state_e;
endpackage

// File: rtl/rdm_fifo.sv
module rdm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rptr];
  assign empty   = (count == '0);
endmodule

// File: rtl/rdm_eor_det.sv
module rdm_eor_det #(
  parameter int         W    = 8,
  parameter logic [7:0] MARK = 8'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         seen
);
  logic prev_hit;
  logic hit;

  assign hit = (wr_data == W'(MARK));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      prev_hit <= 1'b0;
      seen     <= 1'b0;
    end else if (wr_en) begin
      prev_hit <= hit;
      if (hit && prev_hit) seen <= 1'b1;
    end
  end
endmodule

// File: rtl/rdm_ctrl.sv
module rdm_ctrl
  import rdm_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int EXTRA = 4,
  localparam int TW   = $clog2(EXTRA + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NCH-1:0] en_mask,
  input  logic [NCH-1:0] seen,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] wr_en,
  output logic           id_phase,
  output logic           rd_clk,
  output logic           done
);
  rdm_state_e st;
  logic [TW-1:0] tcnt;
  logic all_seen, tick;

  assign all_seen = ((en_q & ~seen) == '0);
  assign tick     = !rd_clk && (((st == ST_RUN) && !all_seen) || (st == ST_TAIL));
  assign id_phase = (st == ST_IDW);
  assign done     = (st == ST_FIN);

  for (genvar k = 0; k < NCH; k++) begin : g_wr
    assign wr_en[k] = en_q[k] && (id_phase || ((st == ST_RUN) && tick && !seen[k]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      rd_clk <= 1'b0;
      tcnt   <= '0;
      en_q   <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_FIN: begin
          rd_clk <= 1'b0;
          if (start) begin
            en_q <= en_mask;
            st   <= ST_IDW;
          end
        end
        ST_IDW: st <= ST_RUN;
        ST_RUN: begin
          if (all_seen) begin
            st   <= ST_TAIL;
            tcnt <= '0;
          end else begin
            rd_clk <= !rd_clk;
          end
        end
        ST_TAIL: begin
          rd_clk <= !rd_clk;
          if (tick) begin
            if (tcnt == TW'(EXTRA - 1)) st <= ST_FIN;
            else tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdm_top.sv
module rdm_top #(
  parameter int         W     = 8,
  parameter int         DEPTH = 2048,
  parameter int         THR   = 3,
  parameter int         EXTRA = 4,
  parameter logic [7:0] MARK  = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    chan_en_i,
  input  logic [3*W-1:0] chan_id_i,
  input  logic [3*W-1:0] chan_data_i,
  output logic          rd_clk_o,
  output logic [2:0]    chan_done_o,
  output logic          done_o,
  output logic          pair_valid_o,
  input  logic          pair_ready_i,
  output logic [2*W-1:0] pair_data_o,
  output logic          solo_valid_o,
  input  logic          solo_ready_i,
  output logic [W-1:0]  solo_data_o
);
  localparam int NCH = 3;
  localparam int CW  = $clog2(DEPTH) + 1;

  logic [NCH-1:0]         wr_en, seen, en_q, empty, rd_en;
  logic [NCH-1:0][W-1:0]  wdata, rdata;
  logic [NCH-1:0][CW-1:0] fcnt;
  logic                   id_phase;
  logic                   pair_full, pair_flush;

  rdm_ctrl #(.NCH(NCH), .EXTRA(EXTRA)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .en_mask  (chan_en_i),
    .seen     (seen),
    .en_q     (en_q),
    .wr_en    (wr_en),
    .id_phase (id_phase),
    .rd_clk   (rd_clk_o),
    .done     (done_o)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign wdata[k] = id_phase ? chan_id_i[k*W +: W] : chan_data_i[k*W +: W];

    rdm_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en[k]),
      .wr_data (wdata[k]),
      .rd_en   (rd_en[k]),
      .rd_data (rdata[k]),
      .count   (fcnt[k]),
      .empty   (empty[k])
    );

    rdm_eor_det #(.W(W), .MARK(MARK)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (id_phase),
      .wr_en   (wr_en[k]),
      .wr_data (wdata[k]),
      .seen    (seen[k])
    );
  end

  assign chan_done_o  = seen;

  assign pair_full    = (fcnt[0] >= CW'(THR)) && (fcnt[1] >= CW'(THR));
  assign pair_flush   = done_o && !empty[0] && !empty[1];
  assign pair_valid_o = pair_full || pair_flush;
  assign pair_data_o  = {rdata[0], rdata[1]};
  assign rd_en[0]     = pair_valid_o && pair_ready_i;
  assign rd_en[1]     = pair_valid_o && pair_ready_i;

  assign solo_valid_o = !empty[2];
  assign solo_data_o  = rdata[2];
  assign rd_en[2]     = solo_valid_o && solo_ready_i;
endmodule

// File: rtl/rdm_checker.sv
module rdm_checker #(
  parameter int W     = 8,
  parameter int DEPTH = 2048,
  parameter int THR   = 3,
  parameter int NCH   = 3,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_clk_o,
  input logic                   done_o,
  input logic                   pair_valid_o,
  input logic                   pair_ready_i,
  input logic [2*W-1:0]         pair_data_o,
  input logic [NCH-1:0]         wr_en,
  input logic [NCH-1:0]         en_q,
  input logic [NCH-1:0][CW-1:0] fcnt
);
  for (genvar k = 0; k < NCH; k++) begin : g_ovf
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[k] |-> (fcnt[k] < CW'(DEPTH))); // R3
  end

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en & ~en_q) == '0); // R4

  AST_PAIR_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid_o && !done_o) |-> (fcnt[0] >= CW'(THR) && fcnt[1] >= CW'(THR))); // R7

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid_o && !pair_ready_i) |=> (pair_valid_o && $stable(pair_data_o))); // R9

  AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> !rd_clk_o); // R6
endmodule

bind rdm_top rdm_checker #(.W(W), .DEPTH(DEPTH), .THR(THR), .NCH(3)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_clk_o     (rd_clk_o),
  .done_o       (done_o),
  .pair_valid_o (pair_valid_o),
  .pair_ready_i (pair_ready_i),
  .pair_data_o  (pair_data_o),
  .wr_en        (wr_en),
  .en_q         (en_q),
  .fcnt         (fcnt)
);

// File: tb/tb_rdm_top.sv
module tb_rdm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  chan_en_i = '0;
  logic [23:0] chan_id_i = '0;
  logic [23:0] chan_data_i = '0;
  logic        rd_clk_o, done_o, pair_valid_o, solo_valid_o;
  logic        pair_ready_i = 1'b0, solo_ready_i = 1'b0;
  logic [2:0]  chan_done_o;
  logic [15:0] pair_data_o;
  logic [7:0]  solo_data_o;

  int total = 0, bad = 0;
  int qa[$], qb[$], qc[$];
  bit rdy_en = 1'b0;
  int cyc = 0;

  always #5 clk = !clk;

  rdm_top dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_en_i(chan_en_i),
    .chan_id_i(chan_id_i), .chan_data_i(chan_data_i), .rd_clk_o(rd_clk_o),
    .chan_done_o(chan_done_o), .done_o(done_o), .pair_valid_o(pair_valid_o),
    .pair_ready_i(pair_ready_i), .pair_data_o(pair_data_o),
    .solo_valid_o(solo_valid_o), .solo_ready_i(solo_ready_i),
    .solo_data_o(solo_data_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wd(int ch, int i, int len, int run);
    if (i >= len) return 8'h00;
    if (i >= len - 2) return 8'hFF;
    if (i == 3 && len > 6) return 8'hFF;
    return 8'((ch * 37 + i * 5 + run * 11) & 8'h7F);
  endfunction

  // ready pattern, driven after the edge
  always @(posedge clk) begin
    #1;
    cyc++;
    pair_ready_i <= rdy_en && (cyc % 3 != 1);
    solo_ready_i <= rdy_en && cyc[0];
  end

  // monitor: compare stream transfers against the scoreboard
  bit          hold_p = 1'b0;
  logic [15:0] hold_d;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_p) begin
        chk(pair_valid_o && pair_data_o == hold_d, "R9 stall hold", pair_data_o, hold_d);
      end
      hold_p = pair_valid_o && !pair_ready_i;
      hold_d = pair_data_o;
      if (pair_valid_o && pair_ready_i) begin
        if (qa.size() == 0 || qb.size() == 0) begin
          chk(1'b0, "R7 unexpected pair", pair_data_o, 0);
        end else begin
          int ea, eb;
          ea = qa.pop_front();
          eb = qb.pop_front();
          chk(pair_data_o == {ea[7:0], eb[7:0]},
              (ea >> 8) == 2 ? "R2 pair id" : "R7 pair data",
              pair_data_o, {ea[7:0], eb[7:0]});
        end
      end
      if (solo_valid_o && solo_ready_i) begin
        if (qc.size() == 0) begin
          chk(1'b0, "R10 unexpected solo", solo_data_o, 0);
        end else begin
          int ec;
          ec = qc.pop_front();
          chk(solo_data_o == ec[7:0], (ec >> 8) == 2 ? "R2 solo id" : "R10 solo data",
              solo_data_o, ec[7:0]);
        end
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  task automatic run_case(input logic [2:0] m, input int la, input int lb, input int lc,
                          input int run, input bit stall, input bit poke);
    int lens[3];
    int maxl = 0, idx = 0, rises = 0;
    bit prev_rc = 1'b0;
    lens[0] = la; lens[1] = lb; lens[2] = lc;
    for (int ch = 0; ch < 3; ch++) begin
      chan_id_i[ch*8 +: 8] = 8'(8'h40 + run * 4 + ch);
      if (m[ch]) begin
        if (lens[ch] > maxl) maxl = lens[ch];
        for (int i = -1; i < lens[ch]; i++) begin
          int v;
          v = (i < 0) ? (2 << 8) | (8'h40 + run * 4 + ch) : (3 << 8) | wd(ch, i, lens[ch], run);
          if (ch == 0) qa.push_back(v);
          else if (ch == 1) qb.push_back(v);
          else qc.push_back(v);
        end
      end
      chan_data_i[ch*8 +: 8] = wd(ch, 0, lens[ch], run);
    end
    chan_en_i = m;
    rdy_en = !stall;
    @(posedge clk); #1;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    do begin
      @(posedge clk); #1;
      start_i = 1'b0;
      if (rd_clk_o && !prev_rc) begin
        rises++;
        idx++;
        for (int ch = 0; ch < 3; ch++) chan_data_i[ch*8 +: 8] = wd(ch, idx, lens[ch], run);
        if (stall && rises == 1) chk(!pair_valid_o, "R7 below threshold", pair_valid_o, 0);
        if (stall && rises == 2) begin
          chk(pair_valid_o, "R7 at threshold", pair_valid_o, 1);
          rdy_en = 1'b1;
        end
        if (poke && rises == 3) start_i = 1'b1;  // R2: ignored mid-run
      end
      prev_rc = rd_clk_o;
    end while (!done_o);
    chk(rises == maxl + 4, "R6 tail edge count", rises, maxl + 4);
    chk(chan_done_o == m, "R5 per-channel done", chan_done_o, m);
    repeat (12) @(posedge clk);
    #1;
    chk(!rd_clk_o && done_o, "R6 parked and held", {rd_clk_o, done_o}, 1);
    if (!m[2]) chk(!solo_valid_o, "R4 disabled channel silent", solo_valid_o, 0);
    repeat (40) @(posedge clk);
    #1;
    chk(qa.size() == 0 && qb.size() == 0, "R8 pair drained", qa.size() + qb.size(), 0);
    chk(qc.size() == 0, "R10 solo drained", qc.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!rd_clk_o && !done_o && chan_done_o == 0 && !pair_valid_o && !solo_valid_o,
        "R1 reset state", {rd_clk_o, done_o, chan_done_o, pair_valid_o, solo_valid_o}, 0);
    rst_n = 1'b1;
    run_case(3'b111, 10, 10, 7, 1, 1'b1, 1'b0);  // R3 R5: lone 0xFF inside
    run_case(3'b011, 8, 8, 3, 2, 1'b0, 1'b0);    // R4: channel 2 masked
    run_case(3'b000, 5, 5, 5, 3, 1'b0, 1'b0);    // R6: empty mask
    run_case(3'b111, 4, 4, 12, 4, 1'b0, 1'b1);   // R8 flush, R2 start ignored
    summary();
    $finish;
  end
endmodule